// File: doc/BRIEF.md
# Two-Channel Interrupt Status Register Unit

This block gathers one-cycle event pulses from two DMA channels, named I and Q, and turns them into a small register set for a bus host. Each channel reports five kinds of event: end-of-line, end-of-window, internal bus error, underrun/overflow and programming error. Every pulse is latched into a raw status register, whether or not its interrupt is enabled. An enable mask selects which latched events count. The masked status view and the single interrupt output are derived from the raw status and that mask.

The host reaches four word registers through a simple bus made of a 2-bit word address, a write strobe, 32-bit write data and combinational 32-bit read data.

- The raw view is read-only.
- The enable mask can only be changed through a write-1-to-set register and a write-1-to-clear register. Reading either of them returns the current mask.
- Writing 1 to a bit of the masked view clears the latched event behind that bit.
- The interrupt output is a registered OR of all masked bits.

Top module: `dual_chan_irq_status`

## Requirements
- R1: After reset the raw status, the enable mask and the interrupt output are all 0, so every register reads 0x00000000.
- R2: Word address 0 is the raw status, 1 is enable-set, 2 is enable-clear and 3 is the masked status. In all four, channel Q occupies bits 12..8 and channel I occupies bits 4..0. Within each channel, event input bit 4 is end-of-line, 3 is end-of-window, 2 is bus error, 1 is underrun/overflow and 0 is programming error.
- R3: Bits 31..13 and 7..5 of every register read as 0, and writing 1 to them changes nothing.
- R4: An event pulse sets its raw status bit at the next clock edge, whether or not that event is enabled. The bit stays set until it is cleared.
- R5: A masked status bit reads 1 only when its raw bit and its enable bit are both 1. While the event is disabled, the masked bit reads 0.
- R6: Writing 1 to a masked status bit clears its raw bit at the next edge, whether or not the event is enabled. Writing 0 leaves it unchanged, and writes to the raw status address have no effect.
- R7: When an event pulse and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R8: Writing 1 to an enable-set bit sets that enable bit, and writing 1 to an enable-clear bit clears it. Writing 0 to either register has no effect. Reading address 1 or 2 returns the enable mask.
- R9: The interrupt output is the registered OR of all masked bits. It goes high one clock after a masked bit becomes 1, and low one clock after the last masked bit becomes 0.
- R10: Enabling an event that is already pending in the raw status makes it read as 1 in the masked view directly after the enable-set write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 5 | Channel I event pulses, one cycle each |
| ev_q | input | 5 | Channel Q event pulses, one cycle each |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_out | output | 1 | Interrupt request |

## Verification
Raw status, enable and clear effects become visible one edge after the pulse or write cycle, and read data follows the address within the same cycle. The interrupt output lags the masked view by one further edge, so it is due two edges after an event pulse on an enabled bit. The bench drives inputs on falling edges and samples read data shortly after a falling edge. It checks the interrupt output both after the first edge, where it must still be low, and after the second edge, where it must be high. The collision case drives the pulse and the clearing write in the very same cycle, and the bench reads the bit back on the following cycle.

// File: rtl/dual_chan_irq_status.sv
module dual_chan_irq_status #(
  parameter int DATA_W = 32,
  parameter int N_EV   = 5,
  parameter int Q_LSB  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EV-1:0]   ev_i,
  input  logic [N_EV-1:0]   ev_q,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam int NB = 2 * N_EV;
  localparam logic [1:0] A_RAW = 2'd0, A_SET = 2'd1, A_CLR = 2'd2, A_MSK = 2'd3;

  function automatic logic [NB-1:0] unpack(input logic [DATA_W-1:0] w);
    return {w[Q_LSB +: N_EV], w[0 +: N_EV]};
  endfunction

  function automatic logic [DATA_W-1:0] pack(input logic [NB-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[Q_LSB +: N_EV] = v[NB-1:N_EV];
    r[0 +: N_EV]     = v[N_EV-1:0];
    return r;
  endfunction

  logic [NB-1:0] raw, en;
  logic [NB-1:0] wbits, ev_vec, masked;
  logic          wr_set, wr_clr, wr_msk;
  logic          unused_wbits;

  assign unused_wbits = ^{reg_wdata[DATA_W-1:Q_LSB+N_EV], reg_wdata[Q_LSB-1:N_EV]};
  assign wbits  = unpack(reg_wdata);
  assign ev_vec = {ev_q, ev_i};
  assign masked = raw & en;
  assign wr_set = reg_wr && reg_addr == A_SET;
  assign wr_clr = reg_wr && reg_addr == A_CLR;
  assign wr_msk = reg_wr && reg_addr == A_MSK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw     <= '0;
      en      <= '0;
      irq_out <= 1'b0;
    end else begin
      raw     <= (raw & ~(wr_msk ? wbits : '0)) | ev_vec;
      en      <= (en | (wr_set ? wbits : '0)) & ~(wr_clr ? wbits : '0);
      irq_out <= |masked;
    end
  end

  always_comb begin
    case (reg_addr)
      A_RAW:   reg_rdata = pack(raw);
      A_SET,
      A_CLR:   reg_rdata = pack(en);
      default: reg_rdata = pack(masked);
    endcase
  end
endmodule

// File: rtl/dual_chan_irq_status_chk.sv
module dual_chan_irq_status_chk #(
  parameter int DATA_W = 32,
  parameter int N_EV   = 5,
  parameter int Q_LSB  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EV-1:0]   ev_i,
  input logic [N_EV-1:0]   ev_q,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_out,
  input logic [2*N_EV-1:0] raw,
  input logic [2*N_EV-1:0] en
);
  localparam logic [DATA_W-1:0] LEGAL =
    DATA_W'((1 << N_EV) - 1) | (DATA_W'((1 << N_EV) - 1) << Q_LSB);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~LEGAL) == '0);

  a_r4_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|{ev_q, ev_i}) |=> ((raw & $past({ev_q, ev_i})) == $past({ev_q, ev_i})));

  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw) & ~$past({ev_q, ev_i})) == '0));

  a_r5_masked_view: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> ((reg_rdata & ~{{(DATA_W-Q_LSB-N_EV){1'b0}}, en[2*N_EV-1:N_EV],
                              {(Q_LSB-N_EV){1'b0}}, en[N_EV-1:0]}) == '0));

  a_r8_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(en));

  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & en) == '0) |=> !irq_out);

  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & en) != '0) |=> irq_out);
endmodule

bind dual_chan_irq_status dual_chan_irq_status_chk #(
  .DATA_W(DATA_W), .N_EV(N_EV), .Q_LSB(Q_LSB)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .ev_q(ev_q), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_out(irq_out),
  .raw(raw), .en(en)
);

// File: tb/dual_chan_irq_status_tb_top.sv
`timescale 1ns/1ps
module dual_chan_irq_status_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [4:0]  ev_i = '0, ev_q = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  dual_chan_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .ev_q(ev_q), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [4:0] pi, input logic [4:0] pq);
    @(negedge clk);
    ev_i = pi; ev_q = pq;
    @(negedge clk);
    ev_i = '0; ev_q = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset reg", d, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_latch_layout();
    logic [31:0] d;
    pulse(5'b10001, 5'b01010);
    rd(2'd0, d);
    chk("R4 R2 raw latch while disabled", d, 32'h00000A11);
    rd(2'd3, d);
    chk("R5 masked zero while disabled", d, 32'h0);
    chk("R9 irq low while disabled", {31'b0, irq_out}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d);
    chk("R8 R3 enable set all", d, 32'h00001F1F);
    wr(2'd1, 32'h0);
    rd(2'd2, d);
    chk("R8 set write 0 no effect", d, 32'h00001F1F);
    wr(2'd2, 32'h0000_0101);
    rd(2'd2, d);
    chk("R8 enable clear", d, 32'h00001E1E);
    wr(2'd2, 32'h0);
    rd(2'd1, d);
    chk("R8 clear write 0 no effect", d, 32'h00001E1E);
    rd(2'd3, d);
    chk("R5 masked equals raw and enable", d, 32'h00000A10);
  endtask

  task automatic t_pending_enable();
    logic [31:0] d;
    wr(2'd1, 32'h0000_0001);
    rd(2'd3, d);
    chk("R10 pending shows after enable", d, 32'h00000A11);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    chk("R6 raw address write ignored", d, 32'h00000A11);
    wr(2'd3, 32'h0);
    rd(2'd0, d);
    chk("R6 write 0 no clear", d, 32'h00000A11);
    wr(2'd2, 32'h0000_0200);
    wr(2'd3, 32'hFFFF_E2E0 | 32'h0000_0210);
    rd(2'd0, d);
    chk("R6 R3 w1c clears incl disabled", d, 32'h00000801);
    rd(2'd1, d);
    chk("R3 reserved write no effect", d, 32'h00001C1F);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk);
    ev_q = 5'b01000; reg_addr = 2'd3; reg_wdata = 32'h0000_0800; reg_wr = 1;
    @(negedge clk);
    ev_q = '0; reg_wr = 0; reg_wdata = '0;
    rd(2'd0, d);
    chk("R7 event wins over clear", d, 32'h00000801);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(2'd3, 32'h0000_1F1F);
    @(negedge clk);
    chk("R9 irq drops after clear", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    ev_i = 5'b00100;
    @(negedge clk);
    ev_i = '0;
    rd(2'd3, d);
    chk("R4 masked set one edge after pulse", d, 32'h00000004);
    chk("R9 irq still low after one edge", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R9 irq high after two edges", {31'b0, irq_out}, 32'h1);
    wr(2'd2, 32'h0000_0004);
    @(negedge clk);
    chk("R9 irq low after disable", {31'b0, irq_out}, 32'h0);
    rd(2'd0, d);
    chk("R5 raw kept while disabled", d, 32'h00000004);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_latch_layout();
        t_enable();
        t_pending_enable();
        t_clear();
        t_collision();
        t_irq();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule